// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer

This block is a numerically controlled oscillator. On every enabled clock it adds a tuning word to a phase register. It then produces a sine sample and a cosine sample of that phase in the same cycle. Both samples come from one read-only magnitude table. The table covers only the rising-and-falling first half of a sine period. For the other half-period, the block negates the table output instead of storing more values.

Two read ports address the table together. One port takes the phase itself. The other takes the phase advanced by a quarter turn. This gives the cosine. Each output pair is a signed sample and comes with a valid strobe. The strobe follows the enable input through the read pipeline. The output frequency is `tune * f_clk / 2^32`. A system sets it by driving the tuning word and holding enable high.

Top module: `quad_dds`

## Requirements
- R1: A synchronous reset sets the phase register to zero and drives `valid` low. The first sample after reset has sine 0 and cosine +4095.
- R2: On every clock with `en` high, the phase register advances by `tune`. With `en` low, the phase holds its value.
- R3: The phase arithmetic wraps modulo 2^32.
- R4: Only phase bits 31:22 are used. Bits 30:22 form the 9-bit table index. Table entry i is round(4095 * sin(pi * i / 512)).
- R5: Phase bit 31 selects the half-period. When it is 0 the output is +entry. When it is 1 the output is -entry.
- R6: The cosine output uses the same decode on (phase + 2^30) mod 2^32.
- R7: The outputs for the phase present in a cycle where `en` is high appear two clock edges later. At that moment `valid` is high. Otherwise `valid` is low.
- R8: The outputs are 13-bit two's complement values and always lie in [-4095, +4095].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance phase and mark sample valid |
| tune | input | 32 | Phase increment per enabled cycle |
| sin_out | output | 13 | Signed sine sample |
| cos_out | output | 13 | Signed cosine sample |
| valid | output | 1 | Sample strobe aligned with outputs |

## Verification
The bench steps the phase by exactly a quarter turn. This gives the sequence 0, +peak, 0, -peak on both outputs, which exposes a wrong offset or a wrong sign. A half-turn step alternates the half-select bit, which isolates the negation path. A near-full-turn step walks the phase backwards across the wrap, which tests the modulo behaviour. Random tuning words with random enable gaps cover arbitrary table indices. They also catch a phase that moves while enable is low, or a strobe that is misaligned with its data.

// File: rtl/quad_dds.sv
module quad_dds #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 9,
  parameter int MAG_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PHASE_W-1:0]      tune,
  output logic signed [MAG_W:0]   sin_out,
  output logic signed [MAG_W:0]   cos_out,
  output logic                    valid
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};
  localparam real PEAK = real'((1 << MAG_W) - 1);
  localparam real PI = 3.14159265358979;

  logic [MAG_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = MAG_W'($rtoi(PEAK * $sin(PI * real'(i) / real'(DEPTH)) + 0.5));
  end

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] cphase;
  logic [MAG_W-1:0]   mag_s, mag_c;
  logic               neg_s, neg_c, v1;

  assign cphase = phase + QUARTER;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (en) phase <= phase + tune;
  end

  always_ff @(posedge clk) begin
    mag_s <= rom[phase[PHASE_W-2 -: IDX_W]];
    mag_c <= rom[cphase[PHASE_W-2 -: IDX_W]];
    neg_s <= phase[PHASE_W-1];
    neg_c <= cphase[PHASE_W-1];
    v1    <= rst ? 1'b0 : en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_out <= '0;
      cos_out <= '0;
      valid   <= 1'b0;
    end else begin
      sin_out <= neg_s ? -$signed({1'b0, mag_s}) : $signed({1'b0, mag_s});
      cos_out <= neg_c ? -$signed({1'b0, mag_c}) : $signed({1'b0, mag_c});
      valid   <= v1;
    end
  end
endmodule

// File: rtl/quad_dds_chk.sv
module quad_dds_chk #(
  parameter int PHASE_W = 32,
  parameter int MAG_W   = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  en,
  input logic [PHASE_W-1:0]    tune,
  input logic [PHASE_W-1:0]    phase,
  input logic signed [MAG_W:0] sin_out,
  input logic signed [MAG_W:0] cos_out,
  input logic                  valid
);
  localparam int LIM = (1 << MAG_W) - 1;
  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (phase == '0) && !valid);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd1) |-> phase == $past(phase) + ($past(en) ? $past(tune) : '0));

  p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) |-> valid == $past(en, 2));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(sin_out) <= LIM) && (int'(sin_out) >= -LIM)
           && (int'(cos_out) <= LIM) && (int'(cos_out) >= -LIM));
endmodule

bind quad_dds quad_dds_chk #(.PHASE_W(PHASE_W), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tune(tune), .phase(phase),
  .sin_out(sin_out), .cos_out(cos_out), .valid(valid)
);

// File: tb/sim_quad_dds.sv
`timescale 1ns/1ps
module sim_quad_dds;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [31:0] tune = '0;
  logic signed [12:0] sin_out, cos_out;
  logic valid;

  quad_dds u0 (.clk(clk), .rst(rst), .en(en), .tune(tune),
               .sin_out(sin_out), .cos_out(cos_out), .valid(valid));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string seg = "R1";
  logic [31:0] m_acc = '0, pp1 = '0, pp2 = '0;
  bit pv1 = 0, pv2 = 0;

  function automatic int wave(input logic [31:0] p);
    int idx = int'(p[30:22]);
    int m = $rtoi(4095.0 * $sin(3.14159265358979 * real'(idx) / 512.0) + 0.5);
    return p[31] ? -m : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, seg, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    repeat (2) @(posedge clk);
    m_acc = '0; pv1 = 0; pv2 = 0;
    @(negedge clk);
    rst = 1'b0;
    check(valid == 1'b0, "R1", int'(valid), 0);
  endtask

  task automatic step(input bit e, input logic [31:0] t);
    int es, ec;
    en = e; tune = t;
    @(posedge clk);
    pv2 = pv1; pp2 = pp1;
    pv1 = e; pp1 = m_acc;
    if (e) m_acc = m_acc + t;
    @(negedge clk);
    check(valid == pv2, "R7", int'(valid), int'(pv2));
    if (pv2) begin
      es = wave(pp2);
      ec = wave(pp2 + 32'h4000_0000);
      check(int'(sin_out) == es, pp2[31] ? "R5" : "R4", int'(sin_out), es);
      check(int'(cos_out) == ec, "R6", int'(cos_out), ec);
      check(int'(sin_out) <= 4095 && int'(sin_out) >= -4095, "R8", int'(sin_out), es);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog [%s] actual=timeout expected=finish", seg);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4242);
    @(negedge clk);
    seg = "R1"; do_reset();
    step(1, 32'd0); step(1, 32'd0); step(1, 32'd0);
    check(int'(sin_out) == 0 && int'(cos_out) == 4095, "R1", int'(cos_out), 4095);

    seg = "R6";
    for (int i = 0; i < 10; i++) step(1, 32'h4000_0000);

    seg = "R5";
    for (int i = 0; i < 6; i++) step(1, 32'h8000_0000);
    for (int i = 0; i < 6; i++) step(1, 32'h8040_0000);

    seg = "R2";
    step(1, 32'h0123_4567);
    for (int i = 0; i < 5; i++) step(0, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) step(1, 32'h0123_4567);

    seg = "R3";
    for (int i = 0; i < 40; i++) step(1, 32'hFFC0_0000);
    for (int i = 0; i < 20; i++) step(1, 32'hF000_0001);

    seg = "R4";
    do_reset();
    for (int i = 0; i < 600; i++) step(1, 32'h0040_0000);

    seg = "R7";
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, $urandom);

    seg = "R1";
    step(1, 32'h1357_9BDF); step(1, 32'h1357_9BDF);
    do_reset();
    step(1, 32'h1000_0000); step(1, 32'h1000_0000); step(1, 32'h1000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule